// File: doc/BRIEF.md
# Memory Register Power-Saving Controller

This block holds the power-management state of a DDR3-style registering command buffer placed between a memory controller and DRAM devices. It watches an active-low reset, a clock-stopped flag, the chip-select inputs and the two clock-enable inputs. From these it produces registered controls for the output drivers: float enables for the chip-select-gated command/address outputs and for the remaining non-clock-enable outputs, drive values for four output clock enables (two copies of each input), an error-output force, an input bus termination enable and a flag that permits control-word access.

Three power-saving mechanisms share a fixed priority. Reset is strongest. Clock-stop standby comes next. It ends only after a programmable run of cycles with a valid, running clock. Clock-enable power-down is entered on an observed falling edge of a clock enable and can keep termination on or switch it off. Chip-select float, the weakest mode, saves termination power while no rank is selected. Clock stop never clears configuration. Only reset does.

Top module: `pwrsave_ctrl`

## Requirements
- R1: While `rst_n` is low, `q_float`=1, `ctl_float`=1, `err_force`=1, `qcke_a`=`qcke_b`=0, `ibt_en`=0 and `cw_ok`=0, independent of the clock. At the first clock edge after release, `err_force` becomes 0.
- R2: At every edge where `clk_stopped`=1 is sampled, the block enters standby. In that cycle and for the rest of standby, `q_float`=1, `ctl_float`=1, `ibt_en`=0 and both output clock-enable pairs are 00.
- R3: Standby ends at the STAB_CYC-th consecutive edge that samples `clk_valid`=1 with `clk_stopped`=0. An edge that samples `clk_valid`=0 restarts the count.
- R4: `cw_ok` is 0 during standby and 1 outside reset and standby.
- R5: Outside standby and power-down, `q_float` = `cfg_float_en` AND (every bit of `cs_n` is 1).
- R6: `ctl_float` is 1 only in reset or standby. Outside standby and power-down, `qcke_a` and `qcke_b` both equal the `cke_in` value sampled at that edge (bit i follows input i).
- R7: With `cfg_pd_en`=1, power-down is entered at an edge where `cke_in`=00 and the `cke_in` sampled at the previous edge had at least one bit 1. If both were already 00, power-down is not entered. With `cfg_pd_en`=0 it is never entered, and power-down is left when `cfg_pd_en` is cleared.
- R8: In power-down, both output clock-enable pairs are 00 and `q_float` = (every bit of `cs_n` is 1), regardless of `cfg_float_en`. A chip select that is low on the entry edge is therefore forwarded with the clock enables low.
- R9: In power-down, `ibt_en` equals `cfg_pd_keep_ibt`. Outside standby and power-down, `ibt_en` is 1.
- R10: Power-down ends at the first edge that samples any `cke_in` bit at 1. At that edge the output clock enables follow `cke_in` and termination is restored.
- R11: Standby takes priority over power-down. A clock stop during power-down clears it, and after standby power-down is entered again only through a new R7 entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stopped | input | 1 | Input clock pair held low |
| clk_valid | input | 1 | Input clock present and stable |
| cs_n | input | NCS | Active-low chip selects |
| cke_in | input | 2 | Clock-enable inputs |
| cfg_float_en | input | 1 | Enable chip-select float |
| cfg_pd_en | input | 1 | Enable clock-enable power-down |
| cfg_pd_keep_ibt | input | 1 | Keep termination on during power-down |
| q_float | output | 1 | Float chip-select-gated outputs |
| ctl_float | output | 1 | Float remaining non-clock-enable outputs |
| qcke_a | output | 2 | Output clock enables, copy A |
| qcke_b | output | 2 | Output clock enables, copy B |
| ibt_en | output | 1 | Input bus termination enable |
| err_force | output | 1 | Force error output high |
| cw_ok | output | 1 | Control-word access permitted |

## Verification
On every cycle, the assertions check four things. Standby always shows floated outputs with clock enables low. Standby is left only after a valid-clock cycle, and the stability count stays in range. Power-down starts only from a falling clock-enable edge with the feature enabled, and ends one edge after a clock enable rises. Termination in power-down follows the configuration bit. Only the bench scenarios can show the exact cycle on which standby ends after an interrupted count, the reset values, the forwarding of a selected command on the entry edge, and the override order when a clock stop meets power-down. A sweep covers every configuration, chip-select pattern and pair of successive clock-enable values.

// File: rtl/pwrsave_pkg.sv
package pwrsave_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_PD   = 2'd1,
    MODE_STBY = 2'd2
  } mode_e;

  // power-down entry: both enables low now, at least one fell since last edge
  function automatic logic pd_entry(input logic [1:0] prev, input logic [1:0] cur);
    return (cur == 2'b00) && ((prev & ~cur) != 2'b00);
  endfunction

  // float for the chip-select gated outputs in run mode
  function automatic logic run_float(input logic all_idle, input logic en);
    return all_idle & en;
  endfunction

endpackage

// File: rtl/pwrsave_standby.sv
module pwrsave_standby #(
  parameter int STAB_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_stopped,
  input  logic clk_valid,
  output logic stby_d,
  output logic stby_q
);
  localparam int CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stable_done;

  assign stable_done = stby_q && !clk_stopped && clk_valid && (cnt_q == LAST);

  always_comb begin
    stby_d = stby_q;
    cnt_d  = '0;
    if (clk_stopped) begin
      stby_d = 1'b1;
    end else if (stby_q && clk_valid) begin
      if (stable_done) stby_d = 1'b0;
      else             cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stby_q <= stby_d;
      cnt_q  <= cnt_d;
    end
  end

  p_exit_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_q) |-> ($past(clk_valid) && !$past(clk_stopped)));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/pwrsave_ckepd.sv
module pwrsave_ckepd
  import pwrsave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cke_in,
  input  logic       cfg_pd_en,
  input  logic       force_clr,
  output logic       pd_d,
  output logic       pd_q
);
  logic [1:0] cke_prev_q;
  logic       entry_ev;
  logic       exit_ev;

  assign entry_ev = cfg_pd_en && pd_entry(cke_prev_q, cke_in);
  assign exit_ev  = (cke_in != 2'b00) || !cfg_pd_en;

  always_comb begin
    if (force_clr)    pd_d = 1'b0;
    else if (pd_q)    pd_d = !exit_ev;
    else              pd_d = entry_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q       <= 1'b0;
      cke_prev_q <= 2'b00;
    end else begin
      pd_q       <= pd_d;
      cke_prev_q <= cke_in;
    end
  end

  p_entry_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> ($past(cfg_pd_en) && ($past(cke_in) == 2'b00)));

  p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && (cke_in != 2'b00)) |=> !pd_q);

endmodule

// File: rtl/pwrsave_outstage.sv
module pwrsave_outstage
  import pwrsave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode_d,
  input  logic       cs_idle,
  input  logic [1:0] cke_in,
  input  logic       cfg_float_en,
  input  logic       cfg_pd_keep_ibt,
  input  logic       stby_q,
  input  logic       pd_q,
  output logic       q_float,
  output logic       ctl_float,
  output logic [1:0] qcke_a,
  output logic [1:0] qcke_b,
  output logic       ibt_en,
  output logic       err_force,
  output logic       cw_ok
);
  logic       qf_d, cf_d, ibt_d, cw_d;
  logic [1:0] cke_d;

  always_comb begin
    unique case (mode_d)
      MODE_STBY: begin
        qf_d = 1'b1; cf_d = 1'b1; cke_d = 2'b00; ibt_d = 1'b0; cw_d = 1'b0;
      end
      MODE_PD: begin
        qf_d = cs_idle; cf_d = 1'b0; cke_d = 2'b00; ibt_d = cfg_pd_keep_ibt; cw_d = 1'b1;
      end
      default: begin
        qf_d = run_float(cs_idle, cfg_float_en); cf_d = 1'b0; cke_d = cke_in;
        ibt_d = 1'b1; cw_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_float   <= 1'b1;
      ctl_float <= 1'b1;
      qcke_a    <= 2'b00;
      qcke_b    <= 2'b00;
      ibt_en    <= 1'b0;
      err_force <= 1'b1;
      cw_ok     <= 1'b0;
    end else begin
      q_float   <= qf_d;
      ctl_float <= cf_d;
      qcke_a    <= cke_d;
      qcke_b    <= cke_d;
      ibt_en    <= ibt_d;
      err_force <= 1'b0;
      cw_ok     <= cw_d;
    end
  end

  p_stby_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stby_q |-> (q_float && ctl_float && !ibt_en && (qcke_a == 2'b00) && (qcke_b == 2'b00)));

  p_stby_cw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stby_q |-> !cw_ok);

  p_pd_ibt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && !stby_q) |-> (ibt_en == $past(cfg_pd_keep_ibt)));

  p_pd_cke_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> ((qcke_a == 2'b00) && (qcke_b == 2'b00)));

endmodule

// File: rtl/pwrsave_ctrl.sv
module pwrsave_ctrl
  import pwrsave_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int STAB_CYC = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clk_stopped,
  input  logic           clk_valid,
  input  logic [NCS-1:0] cs_n,
  input  logic [1:0]     cke_in,
  input  logic           cfg_float_en,
  input  logic           cfg_pd_en,
  input  logic           cfg_pd_keep_ibt,
  output logic           q_float,
  output logic           ctl_float,
  output logic [1:0]     qcke_a,
  output logic [1:0]     qcke_b,
  output logic           ibt_en,
  output logic           err_force,
  output logic           cw_ok
);
  logic  stby_d, stby_q;
  logic  pd_d, pd_q;
  logic  cs_idle;
  mode_e mode_d;

  assign cs_idle = &cs_n;

  always_comb begin
    if (stby_d)    mode_d = MODE_STBY;
    else if (pd_d) mode_d = MODE_PD;
    else           mode_d = MODE_RUN;
  end

  pwrsave_standby #(.STAB_CYC(STAB_CYC)) u_stby (
    .clk(clk), .rst_n(rst_n), .clk_stopped(clk_stopped), .clk_valid(clk_valid),
    .stby_d(stby_d), .stby_q(stby_q)
  );

  pwrsave_ckepd u_pd (
    .clk(clk), .rst_n(rst_n), .cke_in(cke_in), .cfg_pd_en(cfg_pd_en),
    .force_clr(stby_d), .pd_d(pd_d), .pd_q(pd_q)
  );

  pwrsave_outstage u_out (
    .clk(clk), .rst_n(rst_n), .mode_d(mode_d), .cs_idle(cs_idle), .cke_in(cke_in),
    .cfg_float_en(cfg_float_en), .cfg_pd_keep_ibt(cfg_pd_keep_ibt),
    .stby_q(stby_q), .pd_q(pd_q),
    .q_float(q_float), .ctl_float(ctl_float), .qcke_a(qcke_a), .qcke_b(qcke_b),
    .ibt_en(ibt_en), .err_force(err_force), .cw_ok(cw_ok)
  );

  p_no_pd_in_stby_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stby_q |-> !pd_q);

endmodule

// File: tb/pwrsave_ctrl_tb_top.sv
module pwrsave_ctrl_tb_top;
  localparam int NCS  = 2;
  localparam int STAB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic clk_stopped = 1'b0, clk_valid = 1'b1;
  logic [NCS-1:0] cs_n = '1;
  logic [1:0] cke_in = 2'b11;
  logic cfg_float_en = 1'b0, cfg_pd_en = 1'b0, cfg_pd_keep_ibt = 1'b0;
  logic q_float, ctl_float, ibt_en, err_force, cw_ok;
  logic [1:0] qcke_a, qcke_b;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0] m_prev;
  bit m_stby, m_pd;
  int m_cnt;

  always #2.5 clk = ~clk;

  pwrsave_ctrl #(.NCS(NCS), .STAB_CYC(STAB)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_stopped(clk_stopped), .clk_valid(clk_valid),
    .cs_n(cs_n), .cke_in(cke_in), .cfg_float_en(cfg_float_en), .cfg_pd_en(cfg_pd_en),
    .cfg_pd_keep_ibt(cfg_pd_keep_ibt), .q_float(q_float), .ctl_float(ctl_float),
    .qcke_a(qcke_a), .qcke_b(qcke_b), .ibt_en(ibt_en), .err_force(err_force), .cw_ok(cw_ok)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = 2'b00; m_stby = 0; m_pd = 0; m_cnt = 0;
  endtask

  // one edge of the requirement model
  task automatic model_edge();
    bit idle, fell;
    idle = (cs_n == '1);
    fell = (m_prev != 2'b00);
    if (clk_stopped) begin
      m_stby = 1; m_cnt = 0;
    end else if (m_stby) begin
      if (!clk_valid) m_cnt = 0;
      else if (m_cnt + 1 == STAB) begin m_stby = 0; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    if (m_stby) m_pd = 0;
    else if (m_pd) m_pd = cfg_pd_en && (cke_in == 2'b00);
    else m_pd = cfg_pd_en && (cke_in == 2'b00) && fell;
    m_prev = cke_in;
    if (idle) begin end
  endtask

  task automatic check_outputs(input string tag);
    bit idle;
    int e_qf, e_cf, e_cke, e_ibt, e_cw;
    idle = (cs_n == '1);
    if (m_stby) begin
      e_qf = 1; e_cf = 1; e_cke = 0; e_ibt = 0; e_cw = 0;
    end else if (m_pd) begin
      e_qf = idle; e_cf = 0; e_cke = 0; e_ibt = cfg_pd_keep_ibt; e_cw = 1;
    end else begin
      e_qf = idle && cfg_float_en; e_cf = 0; e_cke = cke_in; e_ibt = 1; e_cw = 1;
    end
    chk(tag, "q_float", q_float, e_qf);
    chk(tag, "ctl_float", ctl_float, e_cf);
    chk(tag, "qcke_a", qcke_a, e_cke);
    chk(tag, "qcke_b", qcke_b, e_cke);
    chk(tag, "ibt_en", ibt_en, e_ibt);
    chk(tag, "cw_ok", cw_ok, e_cw);
    chk(tag, "err_force", err_force, 0);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    #1;
    model_edge();
    check_outputs(tag);
  endtask

  task automatic check_reset_state();
    chk("R1", "q_float", q_float, 1);
    chk("R1", "ctl_float", ctl_float, 1);
    chk("R1", "err_force", err_force, 1);
    chk("R1", "qcke_a", qcke_a, 0);
    chk("R1", "qcke_b", qcke_b, 0);
    chk("R1", "ibt_en", ibt_en, 0);
    chk("R1", "cw_ok", cw_ok, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #12;
    check_reset_state();
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step("R1");

    // R5, R6, R7, R8, R9: sweep configuration, chip selects and CKE pairs
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int cs = 0; cs < 4; cs++) begin
        for (int pv = 0; pv < 4; pv++) begin
          for (int cu = 0; cu < 4; cu++) begin
            cfg_float_en = cfg[0]; cfg_pd_en = cfg[1]; cfg_pd_keep_ibt = cfg[2];
            cs_n = '1; cke_in = 2'b11;
            step("R10");
            cke_in = pv[1:0];
            step(cfg[1] ? "R7" : "R5");
            cke_in = cu[1:0]; cs_n = cs[NCS-1:0];
            step(m_pd ? "R8" : "R6");
            step(cfg[1] ? "R9" : "R5");
          end
        end
      end
    end

    // R3, R4: clock stop and interrupted stability count
    cfg_pd_en = 0; cfg_float_en = 1; cs_n = 2'b10; cke_in = 2'b11;
    step("R5");
    clk_stopped = 1;
    step("R2"); step("R2"); step("R4");
    clk_stopped = 0; clk_valid = 0;
    step("R3");
    clk_valid = 1;
    step("R3"); step("R3");
    clk_valid = 0;
    step("R3");
    clk_valid = 1;
    for (int k = 0; k < STAB - 1; k++) begin
      step("R3");
      chk("R3", "cw_ok still low", cw_ok, 0);
    end
    step("R3");
    chk("R3", "cw_ok after count", cw_ok, 1);
    step("R4");

    // R11: clock stop during power-down, then re-entry only via new edge
    cfg_pd_en = 1; cfg_pd_keep_ibt = 1; cs_n = 2'b01; cke_in = 2'b11;
    step("R11");
    cke_in = 2'b00;
    step("R8");
    chk("R8", "forwarded command q_float", q_float, 0);
    step("R9");
    clk_stopped = 1;
    step("R11");
    clk_stopped = 0;
    for (int k = 0; k < STAB; k++) step("R11");
    chk("R11", "ibt after standby without new edge", ibt_en, 1);
    cke_in = 2'b10;
    step("R10");
    cke_in = 2'b00;
    step("R11");
    chk("R11", "ibt in re-entered power-down", ibt_en, 1);
    cke_in = 2'b01;
    step("R10");
    chk("R10", "qcke_a on exit", qcke_a, 1);

    // R1: reset in the middle of operation
    #1 rst_n = 1'b0;
    #1;
    check_reset_state();
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule